// File: doc/BRIEF.md
# Two-Key Write-Protect Gate

This block sits between a register bus and a protected register file. It watches every bus write and passes the write strobe to the register file only while the gate is open. Software opens the gate by storing two fixed 32-bit key words into two dedicated key slots. The first key must be in place before the second key is written. The gate closes again as soon as either slot is overwritten with anything other than its key. The usual way to close it is to write zero to both slots.

Both key slots are always writable, and writes to them never reach the register file. Reads are not affected by the gate. The block does not decode the protected registers: every address other than the two key slots counts as protected. The outputs are the filtered write strobe and a flag that shows whether the gate is open.

Top module: `wp_gate`

## Requirements
- R1: After reset both key slots hold zero and the gate is closed: `unlocked` is 0, and `prot_we` stays 0 even while `bus_we` is high.
- R2: While `unlocked` is 0, a write to any address other than the two key slots leaves `prot_we` at 0.
- R3: Writing 0x83E70B13 to the first key slot (byte address 0x6C) and then 0x95A4F1E0 to the second key slot (byte address 0x70) opens the gate. `unlocked` goes to 1 in the cycle after the second write.
- R4: Writing the second key before the first leaves the gate closed, even though both slots then hold their keys. The second key must be written again once the first key is in place.
- R5: While `unlocked` is 1, `prot_we` equals `bus_we` in the same cycle for every address other than the key slots.
- R6: A write to either key slot never raises `prot_we`, whether the gate is open or closed.
- R7: Writing any value other than its key to either slot, zero included, closes the gate from the next cycle on.
- R8: While the gate is open, writing a slot's own key into that slot again leaves the gate open.
- R9: A value that differs from a key in a single bit counts as a wrong key. It neither opens the gate nor keeps it open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W (8) | Byte address of the bus access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_we | input | 1 | Write strobe from the bus |
| prot_we | output | 1 | Write strobe passed on to the protected register file |
| unlocked | output | 1 | 1 while the gate is open |

## Verification
The gate is driven with the correct key sequence, with the reverse order, with a one-bit-wrong key in each slot, with a key written over the same key, and with relocking through zero and through arbitrary values. Each of these patterns is followed by writes to protected addresses and to the key slots. The tests are built this way so that a slot that compares only one key, a gate that ignores the order of the writes, or a gate that leaks key-slot writes all show up as a wrong `prot_we` value. A reference model in the bench tracks the key words and the order in which they were written, and it is compared with the outputs in every cycle.

// File: rtl/wp_gate_pkg.sv
// Package: shared defaults for the write-protect gate.
// Assumes a byte-addressed bus with 32-bit key words.
package wp_gate_pkg;
    localparam int unsigned WP_ADDR_W = 8;
    localparam int unsigned WP_DATA_W = 32;
    localparam int unsigned WP_NKEYS  = 2;
    localparam logic [WP_ADDR_W-1:0] WP_SLOT0_ADDR = 8'h6C;
    localparam logic [WP_ADDR_W-1:0] WP_SLOT1_ADDR = 8'h70;
    localparam logic [WP_DATA_W-1:0] WP_SLOT0_KEY  = 32'h83E7_0B13;
    localparam logic [WP_DATA_W-1:0] WP_SLOT1_KEY  = 32'h95A4_F1E0;
endpackage

// File: rtl/wp_key_slot.sv
// Module: one always-writable key slot.
// Holds the last word written to its address. It reports whether the
// current access hits the slot, whether the incoming word is the key,
// and whether the stored word is the key.
// Assumes one bus access per cycle; reset clears the stored word.
module wp_key_slot #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter logic [ADDR_W-1:0] SLOT_ADDR = '0,
    parameter logic [DATA_W-1:0] SLOT_KEY  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    output logic              hit,
    output logic              wr,
    output logic              wr_is_key,
    output logic              holds_key
);
    logic [DATA_W-1:0] stored_q;

    // decode the access and compare against the key
    always_comb begin
        hit       = (addr == SLOT_ADDR);
        wr        = hit && we;
        wr_is_key = (wdata == SLOT_KEY);
        holds_key = (stored_q == SLOT_KEY);
    end

    // capture any word written to this slot
    always_ff @(posedge clk) begin
        if (!rst_n)
            stored_q <= '0;
        else if (wr)
            stored_q <= wdata;
    end
endmodule

// File: rtl/wp_order_track.sv
// Module: tracks whether the keys arrived in the required order.
// The flag sets when the second slot gets its key while the first slot
// already holds its key. It clears when either slot gets a non-key word.
// Assumes the two slot writes are mutually exclusive (distinct addresses).
module wp_order_track (
    input  logic clk,
    input  logic rst_n,
    input  logic first_wr,
    input  logic first_wr_key,
    input  logic second_wr,
    input  logic second_wr_key,
    input  logic first_holds_key,
    output logic armed
);
    // update the ordered-unlock flag on slot writes
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (second_wr)
            armed <= second_wr_key && first_holds_key;
        else if (first_wr)
            armed <= armed && first_wr_key;
    end
endmodule

// File: rtl/wp_gate.sv
// Module: top of the two-key write-protect gate.
// Passes bus write strobes to the protected register file only while
// both key slots hold their keys and the keys were written in order.
// Key-slot writes never reach the register file. Reads are not gated.
// Assumes every address outside the two key slots is protected.
module wp_gate
    import wp_gate_pkg::*;
#(
    parameter int unsigned ADDR_W = WP_ADDR_W,
    parameter int unsigned DATA_W = WP_DATA_W,
    parameter logic [ADDR_W-1:0] SLOT0_ADDR = WP_SLOT0_ADDR,
    parameter logic [ADDR_W-1:0] SLOT1_ADDR = WP_SLOT1_ADDR,
    parameter logic [DATA_W-1:0] SLOT0_KEY  = WP_SLOT0_KEY,
    parameter logic [DATA_W-1:0] SLOT1_KEY  = WP_SLOT1_KEY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic              prot_we,
    output logic              unlocked
);
    localparam int unsigned NK = WP_NKEYS;
    localparam logic [NK-1:0][ADDR_W-1:0] SLOT_ADDRS = {SLOT1_ADDR, SLOT0_ADDR};
    localparam logic [NK-1:0][DATA_W-1:0] SLOT_KEYS  = {SLOT1_KEY, SLOT0_KEY};

    logic [NK-1:0] s_hit, s_wr, s_wr_key, s_held;
    logic          armed;

    // one slot instance per key
    for (genvar i = 0; i < NK; i++) begin : g_slot
        wp_key_slot #(
            .ADDR_W   (ADDR_W),
            .DATA_W   (DATA_W),
            .SLOT_ADDR(SLOT_ADDRS[i]),
            .SLOT_KEY (SLOT_KEYS[i])
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .addr     (bus_addr),
            .wdata    (bus_wdata),
            .we       (bus_we),
            .hit      (s_hit[i]),
            .wr       (s_wr[i]),
            .wr_is_key(s_wr_key[i]),
            .holds_key(s_held[i])
        );
    end

    wp_order_track u_order (
        .clk            (clk),
        .rst_n          (rst_n),
        .first_wr       (s_wr[0]),
        .first_wr_key   (s_wr_key[0]),
        .second_wr      (s_wr[1]),
        .second_wr_key  (s_wr_key[1]),
        .first_holds_key(s_held[0]),
        .armed          (armed)
    );

    // open only with ordered keys still in place; filter the strobe
    always_comb begin
        unlocked = armed && (&s_held);
        prot_we  = bus_we && unlocked && !(|s_hit);
    end
endmodule

// File: rtl/wp_gate_chk.sv
// Module: property checker for wp_gate, attached by bind.
// Observes only the ports of the gate.
module wp_gate_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter logic [ADDR_W-1:0] SLOT0_ADDR = '0,
    parameter logic [ADDR_W-1:0] SLOT1_ADDR = '0,
    parameter logic [DATA_W-1:0] SLOT0_KEY  = '0,
    parameter logic [DATA_W-1:0] SLOT1_KEY  = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic              prot_we,
    input logic              unlocked
);
    logic slot_acc;
    assign slot_acc = (bus_addr == SLOT0_ADDR) || (bus_addr == SLOT1_ADDR);

    p_closed_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |-> !prot_we);

    p_open_passes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && bus_we && !slot_acc) |-> prot_we);

    p_slot_no_leak_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && slot_acc) |-> !prot_we);

    p_open_after_key2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(bus_we && bus_addr == SLOT1_ADDR && bus_wdata == SLOT1_KEY));

    p_relock_slot0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == SLOT0_ADDR && bus_wdata != SLOT0_KEY) |=> !unlocked);

    p_relock_slot1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == SLOT1_ADDR && bus_wdata != SLOT1_KEY) |=> !unlocked);
endmodule

bind wp_gate wp_gate_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SLOT0_ADDR(SLOT0_ADDR), .SLOT1_ADDR(SLOT1_ADDR),
    .SLOT0_KEY(SLOT0_KEY), .SLOT1_KEY(SLOT1_KEY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .prot_we(prot_we), .unlocked(unlocked)
);

// File: tb/wp_gate_tb.sv
// Bench: drives bus writes on the falling edge, compares against a
// behavioural reference model every cycle, counts checks and failures.
module wp_gate_tb;
    localparam int CLK_P = 10;
    localparam logic [7:0]  A0 = 8'h6C;
    localparam logic [7:0]  A1 = 8'h70;
    localparam logic [31:0] K0 = 32'h83E7_0B13;
    localparam logic [31:0] K1 = 32'h95A4_F1E0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        prot_we, unlocked;

    int total = 0;
    int bad = 0;

    // reference model state
    logic [31:0] m_s0 = '0, m_s1 = '0;
    bit          m_order = 0;

    always #(CLK_P/2) clk = ~clk;

    wp_gate u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .prot_we(prot_we), .unlocked(unlocked)
    );

    function automatic bit m_open();
        return m_order && (m_s0 == K0) && (m_s1 == K1);
    endfunction

    task automatic check(input string req, input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // one bus cycle: drive, compare outputs, advance the model
    task automatic cyc(input logic [7:0] a, input logic [31:0] d, input logic we, input string req);
        bit exp_pw;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = we;
        #(CLK_P/4);
        exp_pw = we && m_open() && (a != A0) && (a != A1);
        check(req, unlocked, m_open(), "unlocked");
        check(req, prot_we, exp_pw, "prot_we");
        @(posedge clk);
        if (we && a == A0) begin
            m_s0 = d;
            m_order = m_order && (d == K0);
        end else if (we && a == A1) begin
            m_order = (d == K1) && (m_s0 == K0);
            m_s1 = d;
        end
    endtask

    initial begin
        #(CLK_P * 20000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state, strobe held high during reset
        bus_we = 1'b1; bus_addr = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", unlocked, 1'b0, "unlocked in reset");
        rst_n = 1'b1;
        cyc(8'h00, 32'h1, 1, "R1");
        // R2: closed gate blocks protected writes
        cyc(8'h40, 32'h5, 1, "R2");
        cyc(8'h44, 32'h5, 1, "R2");
        // R4: reverse order stays closed
        cyc(A1, K1, 1, "R4");
        cyc(A0, K0, 1, "R4");
        cyc(8'h08, 32'h3, 1, "R4");
        cyc(8'h08, 32'h3, 1, "R4");
        // R3: now kick1 again with kick0 in place opens
        cyc(A1, K1, 1, "R3");
        cyc(8'h08, 32'h3, 1, "R3");
        // R5: strobe follows bus_we when open
        cyc(8'h10, 32'h7, 0, "R5");
        cyc(8'h14, 32'h7, 1, "R5");
        cyc(8'h6D, 32'h7, 1, "R5");
        // R6: key slot writes never leak
        cyc(A0, K0, 1, "R6");
        cyc(A1, K1, 1, "R6");
        // R8: rewriting own keys keeps it open
        cyc(8'h20, 32'h9, 1, "R8");
        // R7: zero relocks
        cyc(A0, 32'h0, 1, "R7");
        cyc(8'h20, 32'h9, 1, "R7");
        cyc(A1, 32'h0, 1, "R7");
        cyc(8'h20, 32'h9, 1, "R7");
        // R3: proper sequence from zero
        cyc(A0, K0, 1, "R3");
        cyc(A1, K1, 1, "R3");
        cyc(8'h24, 32'h1, 1, "R3");
        // R7: arbitrary value in slot 1 relocks
        cyc(A1, 32'hDEAD_BEEF, 1, "R7");
        cyc(8'h24, 32'h1, 1, "R7");
        // R9: one-bit-wrong keys
        cyc(A0, K0 ^ 32'h0000_0100, 1, "R9");
        cyc(A1, K1, 1, "R9");
        cyc(8'h24, 32'h1, 1, "R9");
        cyc(A0, K0, 1, "R9");
        cyc(A1, K1 ^ 32'h8000_0000, 1, "R9");
        cyc(8'h24, 32'h1, 1, "R9");
        cyc(A1, K1, 1, "R9");
        cyc(8'h24, 32'h1, 1, "R9");
        cyc(A0, K0 ^ 32'h1, 1, "R9");
        cyc(8'h24, 32'h1, 1, "R9");
        // R6: slot writes while closed also blocked
        cyc(A0, 32'h0, 1, "R6");
        cyc(A1, 32'h0, 1, "R6");
        cyc(8'h00, 32'h0, 0, "R2");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule